// File: doc/BRIEF.md
# Streaming Entropy Health Monitor

This block watches a raw random bit stream, one bit per cycle under a valid strobe, and a separate stream of finished output words. It runs five online checks and raises a one-cycle failure pulse for each one that trips. Two checks look at runs of identical bits, two are block statistics over a fixed block of raw bits, and one compares each output word with the one before it.

The block statistics collect a fixed number of accepted bits (20,000 by default). On the cycle after the last bit of a block, a block-done flag pulses together with the verdicts of the ones-count test and the nibble-frequency test. The run detectors see the stream as one continuous sequence that does not stop at block boundaries. A clear input, or a low enable, resets every counter and the stored word.

All outputs are registered, so each pulse comes one cycle after the input that caused it.

Top module: `entropy_health_monitor`

## Requirements
- R1: `block_done` pulses for one cycle, in the cycle after every 20,000th accepted bit. An accepted bit is a cycle with `bit_valid` high, `enable` high and `clear` low. Cycles without an accepted bit do not advance the block.
- R2: `monobit_fail` pulses with `block_done` unless the number of ones in the block is strictly greater than 9654 and strictly less than 10346.
- R3: The block is cut into 5000 non-overlapping nibbles, and the first bit of each nibble is the most significant. With S the sum of the squares of the 16 pattern counts, `poker_fail` pulses with `block_done` unless 25,005,150 < 16·S < 25,287,000.
- R4: `poker_fail` also pulses with `block_done` when any of the 16 pattern counts is below 214 or above 411.
- R5: `long_run_fail` pulses in the cycle after the accepted bit that makes a run of identical bits reach 34. It pulses once per run, and runs continue across block boundaries.
- R6: `noise_run_fail` pulses in the cycle after the accepted bit that makes a run reach 48. It pulses once per run and does not pulse again while the run goes on.
- R7: `stuck_fail` pulses in the cycle after an accepted word (`word_valid`, `enable` high, `clear` low) that equals the previous accepted word.
- R8: `clear` resets the block position, the counts, the run length and the stored word. Bits and words offered in a clear cycle are ignored, and the first word after a clear is never reported as stuck.
- R9: While `enable` is low the block behaves as if `clear` were held: inputs are ignored and all state returns to its start.
- R10: During reset, and in the first cycle after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Monitor enable; low flushes all state |
| clear | input | 1 | Synchronous flush of all state |
| bit_valid | input | 1 | Raw bit strobe |
| bit_in | input | 1 | Raw random bit |
| word_valid | input | 1 | Output word strobe |
| word_in | input | WORD_W | Completed output word |
| long_run_fail | output | 1 | Run reached the long limit |
| noise_run_fail | output | 1 | Run reached the noise limit |
| monobit_fail | output | 1 | Ones count out of bounds |
| poker_fail | output | 1 | Nibble statistic or pattern count out of bounds |
| stuck_fail | output | 1 | Word repeated the previous one |
| block_done | output | 1 | Block of bits completed |

## Verification
The bench feeds blocks whose 16 nibble counts are chosen exactly, sending each pattern in round-robin order. A nearly uniform block falls below the lower bound of the statistic. A balanced block passes every test. A block with one pattern count over its limit fails only the pattern-count check. Four blocks place the ones count exactly on and exactly inside each bound. Separate bit sequences build runs of 33, 34, 48 and more identical bits, break a run with a clear or a low enable, and insert idle cycles inside a block. Word sequences repeat a value, repeat it again, and repeat it across a clear, which separates a real stuck output from the first word after a flush.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
   localparam int NIB_W     = 4;
   localparam int NUM_CELLS = 1 << NIB_W;

   typedef struct packed {
      logic done;
      logic mono_bad;
      logic poker_bad;
   } blk_verdict_t;
endpackage

// File: rtl/ehm_run_tracker.sv
module ehm_run_tracker #(
   parameter int LONG_RUN  = 34,
   parameter int NOISE_RUN = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic stb,
   input  logic bit_in,
   output logic long_hit,
   output logic noise_hit
);
   localparam int RW = $clog2(NOISE_RUN + 1);

   logic          last_q;
   logic [RW-1:0] len_q;
   logic [RW-1:0] len_nx;
   logic          same;

   assign same   = (len_q != '0) && (bit_in == last_q);
   assign len_nx = !same ? RW'(1) :
                   (len_q == RW'(NOISE_RUN)) ? len_q : len_q + RW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q    <= 1'b0;
         len_q     <= '0;
         long_hit  <= 1'b0;
         noise_hit <= 1'b0;
      end else if (flush) begin
         last_q    <= 1'b0;
         len_q     <= '0;
         long_hit  <= 1'b0;
         noise_hit <= 1'b0;
      end else begin
         long_hit  <= stb && (len_nx == RW'(LONG_RUN))  && (len_q != RW'(LONG_RUN));
         noise_hit <= stb && (len_nx == RW'(NOISE_RUN)) && (len_q != RW'(NOISE_RUN));
         if (stb) begin
            last_q <= bit_in;
            len_q  <= len_nx;
         end
      end
   end
endmodule

// File: rtl/ehm_block_stats.sv
module ehm_block_stats
   import ehm_pkg::*;
#(
   parameter int BLOCK_BITS  = 20000,
   parameter int MONO_LO     = 9654,
   parameter int MONO_HI     = 10346,
   parameter int CELL_LO     = 214,
   parameter int CELL_HI     = 411,
   parameter int PK_LO_CENTI = 103,
   parameter int PK_HI_CENTI = 5740
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic stb,
   input  logic bit_in,
   output logic done,
   output logic mono_fail,
   output logic poker_fail
);
   localparam int NIBBLES = BLOCK_BITS / NIB_W;
   localparam int PW      = $clog2(BLOCK_BITS + 1);
   localparam int CW      = $clog2(NIBBLES + 1);
   localparam longint unsigned NN = longint'(NIBBLES) * longint'(NIBBLES);
   localparam int SW      = $clog2(NN + 1);
   localparam int SCW     = SW + 11;
   localparam longint unsigned LO_L = 100 * NN + longint'(NIBBLES) * longint'(PK_LO_CENTI);
   localparam longint unsigned HI_L = 100 * NN + longint'(NIBBLES) * longint'(PK_HI_CENTI);
   localparam logic [SCW-1:0] LO_S = SCW'(LO_L);
   localparam logic [SCW-1:0] HI_S = SCW'(HI_L);

   logic [PW-1:0]                pos_q, ones_q, ones_nx;
   logic [NIB_W-2:0]             sh_q;
   logic [NUM_CELLS-1:0][CW-1:0] cell_q, cell_nx;
   logic [SW-1:0]                sq_q, sq_nx;
   logic [NIB_W-1:0]             nib;
   logic                         nib_end, last_bit;
   logic [CW-1:0]                cell_sel;
   logic [NUM_CELLS-1:0]         cell_bad;
   logic [SCW-1:0]               stat;
   blk_verdict_t                 verdict_q, verdict_nx;

   assign nib      = {sh_q, bit_in};
   assign nib_end  = (pos_q[1:0] == 2'b11);
   assign last_bit = (pos_q == PW'(BLOCK_BITS - 1));
   assign ones_nx  = ones_q + PW'(bit_in);
   assign cell_sel = cell_q[nib];
   assign sq_nx    = sq_q + (nib_end ? SW'({cell_sel, 1'b1}) : '0);

   for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
      assign cell_nx[g]  = cell_q[g] + CW'(nib_end && (nib == NIB_W'(g)));
      assign cell_bad[g] = (cell_nx[g] < CW'(CELL_LO)) || (cell_nx[g] > CW'(CELL_HI));
   end

   assign stat = SCW'(sq_nx) * SCW'(1600);

   always_comb begin
      verdict_nx.done      = 1'b1;
      verdict_nx.mono_bad  = !((ones_nx > PW'(MONO_LO)) && (ones_nx < PW'(MONO_HI)));
      verdict_nx.poker_bad = !((stat > LO_S) && (stat < HI_S)) || (|cell_bad);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q     <= '0;
         ones_q    <= '0;
         sh_q      <= '0;
         cell_q    <= '0;
         sq_q      <= '0;
         verdict_q <= '0;
      end else if (flush) begin
         pos_q     <= '0;
         ones_q    <= '0;
         sh_q      <= '0;
         cell_q    <= '0;
         sq_q      <= '0;
         verdict_q <= '0;
      end else begin
         verdict_q <= '0;
         if (stb) begin
            if (last_bit) begin
               verdict_q <= verdict_nx;
               pos_q     <= '0;
               ones_q    <= '0;
               sh_q      <= '0;
               cell_q    <= '0;
               sq_q      <= '0;
            end else begin
               pos_q  <= pos_q + PW'(1);
               ones_q <= ones_nx;
               sh_q   <= nib[NIB_W-2:0];
               cell_q <= cell_nx;
               sq_q   <= sq_nx;
            end
         end
      end
   end

   assign done       = verdict_q.done;
   assign mono_fail  = verdict_q.mono_bad;
   assign poker_fail = verdict_q.poker_bad;
endmodule

// File: rtl/ehm_stuck_word.sv
module ehm_stuck_word #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              stb,
   input  logic [WORD_W-1:0] word_in,
   output logic              stuck
);
   logic [WORD_W-1:0] prev_q;
   logic              have_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         have_q <= 1'b0;
         stuck  <= 1'b0;
      end else if (flush) begin
         prev_q <= '0;
         have_q <= 1'b0;
         stuck  <= 1'b0;
      end else begin
         stuck <= stb && have_q && (word_in == prev_q);
         if (stb) begin
            prev_q <= word_in;
            have_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/entropy_health_monitor.sv
module entropy_health_monitor #(
   parameter int WORD_W      = 32,
   parameter int BLOCK_BITS  = 20000,
   parameter int LONG_RUN    = 34,
   parameter int NOISE_RUN   = 48,
   parameter int MONO_LO     = 9654,
   parameter int MONO_HI     = 10346,
   parameter int CELL_LO     = 214,
   parameter int CELL_HI     = 411,
   parameter int PK_LO_CENTI = 103,
   parameter int PK_HI_CENTI = 5740,
   parameter bit STUCK_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              clear,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_in,
   output logic              long_run_fail,
   output logic              noise_run_fail,
   output logic              monobit_fail,
   output logic              poker_fail,
   output logic              stuck_fail,
   output logic              block_done
);
   logic flush, bit_stb, word_stb;

   initial begin
      if (BLOCK_BITS % 4 != 0 || BLOCK_BITS < 64)
         $error("block length must be a multiple of 4 and at least 64");
      if (LONG_RUN < 2 || LONG_RUN >= NOISE_RUN)
         $error("run limits must satisfy 2 <= long < noise");
      if (MONO_LO >= MONO_HI || CELL_LO > CELL_HI || PK_LO_CENTI >= PK_HI_CENTI)
         $error("lower bounds must lie below upper bounds");
   end

   assign flush    = clear || !enable;
   assign bit_stb  = bit_valid && !flush;
   assign word_stb = word_valid && !flush;

   ehm_run_tracker #(
      .LONG_RUN (LONG_RUN),
      .NOISE_RUN(NOISE_RUN)
   ) u_runs (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .stb      (bit_stb),
      .bit_in   (bit_in),
      .long_hit (long_run_fail),
      .noise_hit(noise_run_fail)
   );

   ehm_block_stats #(
      .BLOCK_BITS (BLOCK_BITS),
      .MONO_LO    (MONO_LO),
      .MONO_HI    (MONO_HI),
      .CELL_LO    (CELL_LO),
      .CELL_HI    (CELL_HI),
      .PK_LO_CENTI(PK_LO_CENTI),
      .PK_HI_CENTI(PK_HI_CENTI)
   ) u_block (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .stb       (bit_stb),
      .bit_in    (bit_in),
      .done      (block_done),
      .mono_fail (monobit_fail),
      .poker_fail(poker_fail)
   );

   if (STUCK_EN) begin : g_stuck
      ehm_stuck_word #(.WORD_W(WORD_W)) u_stuck (
         .clk    (clk),
         .rst_n  (rst_n),
         .flush  (flush),
         .stb    (word_stb),
         .word_in(word_in),
         .stuck  (stuck_fail)
      );
   end else begin : g_no_stuck
      logic unused_word;
      assign unused_word = word_stb ^ (|word_in);
      assign stuck_fail  = 1'b0;
   end
endmodule

// File: rtl/ehm_checker.sv
module ehm_checker #(
   parameter int BLOCK_BITS = 20000
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic clear,
   input logic bit_valid,
   input logic word_valid,
   input logic long_run_fail,
   input logic noise_run_fail,
   input logic monobit_fail,
   input logic poker_fail,
   input logic stuck_fail,
   input logic block_done
);
   localparam int PW = $clog2(BLOCK_BITS + 1);

   logic          any_pulse;
   logic [PW-1:0] seen_q;

   assign any_pulse = long_run_fail || noise_run_fail || monobit_fail ||
                      poker_fail || stuck_fail || block_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    seen_q <= '0;
      else if (clear || !enable)     seen_q <= '0;
      else if (bit_valid)            seen_q <= (seen_q == PW'(BLOCK_BITS - 1)) ? '0 : seen_q + PW'(1);
   end

   assert_done_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      block_done |-> ($past(seen_q) == PW'(BLOCK_BITS - 1)) && $past(bit_valid && enable && !clear));
   assert_mono_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      monobit_fail |-> block_done);
   assert_poker_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      poker_fail |-> block_done);
   assert_long_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      long_run_fail |-> $past(bit_valid && enable && !clear));
   assert_long_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      long_run_fail |=> !long_run_fail);
   assert_noise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      noise_run_fail |=> !noise_run_fail);
   assert_run_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({long_run_fail, noise_run_fail}));
   assert_stuck_after_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_fail |-> $past(word_valid && enable && !clear));
   assert_clear_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> !any_pulse);
   assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!enable) |-> !any_pulse);
   assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !any_pulse);
endmodule

bind entropy_health_monitor ehm_checker #(.BLOCK_BITS(BLOCK_BITS)) u_ehm_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable        (enable),
   .clear         (clear),
   .bit_valid     (bit_valid),
   .word_valid    (word_valid),
   .long_run_fail (long_run_fail),
   .noise_run_fail(noise_run_fail),
   .monobit_fail  (monobit_fail),
   .poker_fail    (poker_fail),
   .stuck_fail    (stuck_fail),
   .block_done    (block_done)
);

// File: tb/entropy_health_monitor_test.sv
`timescale 1ns/1ps
module entropy_health_monitor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b1;
   logic        clear = 1'b0;
   logic        bit_valid = 1'b0;
   logic        bit_in = 1'b0;
   logic        word_valid = 1'b0;
   logic [31:0] word_in = '0;
   logic        long_run_fail, noise_run_fail, monobit_fail, poker_fail, stuck_fail, block_done;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;
   string phase = "reset";

   // requirement-level model state
   int          m_len, m_pos, m_ones;
   bit          m_last;
   int          m_cnt[16];
   logic [3:0]  m_sh;
   logic [31:0] m_prev;
   bit          m_have;

   always #2.5 clk = ~clk;

   entropy_health_monitor uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
      .bit_valid(bit_valid), .bit_in(bit_in), .word_valid(word_valid), .word_in(word_in),
      .long_run_fail(long_run_fail), .noise_run_fail(noise_run_fail),
      .monobit_fail(monobit_fail), .poker_fail(poker_fail),
      .stuck_fail(stuck_fail), .block_done(block_done)
   );

   task automatic model_reset();
      m_len = 0; m_last = 0; m_pos = 0; m_ones = 0; m_sh = '0;
      m_have = 0; m_prev = '0;
      for (int i = 0; i < 16; i++) m_cnt[i] = 0;
   endtask

   task automatic chk(input string req, input string name, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s [%s] %s actual=%0b expected=%0b", req, phase, name, act, exp);
      end
   endtask

   // one cycle: drive at negedge, sample 1 ns after the next posedge
   task automatic step(input bit en, input bit clr, input bit bv, input bit b,
                       input bit wv, input logic [31:0] w);
      bit e_long, e_noise, e_mono, e_poker, e_stuck, e_done;
      e_long = 0; e_noise = 0; e_mono = 0; e_poker = 0; e_stuck = 0; e_done = 0;
      enable = en; clear = clr; bit_valid = bv; bit_in = b; word_valid = wv; word_in = w;
      if (!en || clr) begin
         model_reset();
      end else begin
         if (bv) begin
            int old;
            old = m_len;
            if (m_len != 0 && b == m_last) begin
               if (m_len < 48) m_len++;
            end else m_len = 1;
            m_last = b;
            e_long  = (m_len == 34) && (old != 34);
            e_noise = (m_len == 48) && (old != 48);
            m_ones += int'(b);
            m_sh = {m_sh[2:0], b};
            if (m_pos % 4 == 3) m_cnt[m_sh]++;
            if (m_pos == 19999) begin
               longint s;
               bit cells_ok;
               s = 0; cells_ok = 1;
               for (int i = 0; i < 16; i++) begin
                  s += longint'(m_cnt[i]) * m_cnt[i];
                  if (m_cnt[i] < 214 || m_cnt[i] > 411) cells_ok = 0;
               end
               e_done  = 1;
               e_mono  = !(m_ones > 9654 && m_ones < 10346);
               e_poker = !(16 * s > 25005150 && 16 * s < 25287000 && cells_ok);
               m_pos = 0; m_ones = 0; m_sh = '0;
               for (int i = 0; i < 16; i++) m_cnt[i] = 0;
            end else m_pos++;
         end
         if (wv) begin
            e_stuck = m_have && (w == m_prev);
            m_prev = w; m_have = 1;
         end
      end
      @(posedge clk); #1;
      chk("R1", "block_done", block_done, e_done);
      chk("R2", "monobit_fail", monobit_fail, e_mono);
      chk("R3/R4", "poker_fail", poker_fail, e_poker);
      chk("R5", "long_run_fail", long_run_fail, e_long);
      chk("R6", "noise_run_fail", noise_run_fail, e_noise);
      chk("R7", "stuck_fail", stuck_fail, e_stuck);
      @(negedge clk);
   endtask

   task automatic bits(input int n, input bit v);
      for (int i = 0; i < n; i++) step(1, 0, 1, v, 0, '0);
   endtask

   task automatic word(input logic [31:0] w);
      step(1, 0, 0, 0, 1, w);
   endtask

   // one block from exact nibble counts, patterns interleaved round-robin
   task automatic run_block(input int c[16], input bit gaps);
      int rem[16];
      int p;
      p = 0;
      for (int i = 0; i < 16; i++) rem[i] = c[i];
      for (int k = 0; k < 5000; k++) begin
         logic [3:0] nb;
         while (rem[p] == 0) p = (p + 1) % 16;
         nb = 4'(p);
         rem[p]--;
         p = (p + 1) % 16;
         for (int j = 3; j >= 0; j--) begin
            if (gaps && (k % 250 == 0) && j == 1) step(1, 0, 0, 0, 0, '0);
            step(1, 0, 1, nb[j], 0, '0);
         end
      end
      step(1, 0, 0, 0, 0, '0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog [%s] actual=timeout expected=completion", phase);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      int c[16];
      model_reset();
      repeat (3) @(negedge clk);
      // R10: outputs low during reset
      chk("R10", "any output in reset",
          long_run_fail | noise_run_fail | monobit_fail | poker_fail | stuck_fail | block_done, 1'b0);
      rst_n = 1'b1;
      phase = "R10 after reset";
      step(1, 0, 0, 0, 0, '0);

      phase = "R5 R6 runs";
      bits(33, 1); bits(1, 0);          // 33 then break: no pulse
      bits(60, 1);                      // R5 at 34, R6 at 48, none after
      bits(34, 0);                      // R5 on zeros
      phase = "R9 enable low breaks run";
      bits(30, 1);
      step(0, 0, 1, 1, 0, '0);
      step(0, 0, 1, 1, 0, '0);
      bits(33, 1);                      // run restarted: no pulse
      bits(1, 1);                       // 34th after restart: R5
      phase = "R8 clear breaks run";
      bits(20, 0);
      step(1, 1, 1, 0, 0, '0);
      bits(33, 0); bits(1, 0);

      phase = "R7 words";
      word(32'hA5A5_0001); word(32'h1234_5678); word(32'h1234_5678); word(32'h1234_5678);
      word(32'h0000_0000);
      phase = "R8 first word after clear";
      step(1, 1, 0, 0, 1, 32'h0000_0000);
      word(32'h0000_0000); word(32'h0000_0000);
      phase = "R9 first word after enable low";
      step(0, 0, 0, 0, 1, 32'h0000_0000);
      word(32'h0000_0000); word(32'hFFFF_FFFF);

      phase = "R8 partial block then clear";
      bits(100, 1);
      step(1, 1, 0, 0, 0, '0);

      phase = "R3 uniform block below lower bound";
      for (int i = 0; i < 16; i++) c[i] = (i < 8) ? 313 : 312;
      run_block(c, 0);

      phase = "R1 R2 R3 balanced block with idle gaps";
      for (int i = 0; i < 16; i++) c[i] = (i < 8) ? 330 : 295;
      run_block(c, 1);
      step(1, 1, 0, 0, 0, '0);

      phase = "R4 single cell above limit";
      c[0] = 413;
      for (int i = 1; i < 16; i++) c[i] = (i <= 12) ? 306 : 305;
      run_block(c, 0);
      step(1, 1, 0, 0, 0, '0);

      phase = "R2 ones at 9654";
      for (int i = 0; i < 16; i++) c[i] = (i < 8) ? 356 : 269;
      c[0] = 355; c[3] = 357;
      run_block(c, 0);
      step(1, 1, 0, 0, 0, '0);

      phase = "R2 ones at 9655";
      for (int i = 0; i < 16; i++) c[i] = (i < 8) ? 356 : 269;
      c[0] = 355; c[7] = 357;
      run_block(c, 0);
      step(1, 1, 0, 0, 0, '0);

      phase = "R2 ones at 10346";
      for (int i = 0; i < 16; i++) c[i] = (i < 8) ? 269 : 356;
      c[15] = 355; c[3] = 270;
      run_block(c, 0);
      step(1, 1, 0, 0, 0, '0);

      phase = "R2 ones at 10345";
      for (int i = 0; i < 16; i++) c[i] = (i < 8) ? 269 : 356;
      c[15] = 355; c[1] = 270;
      run_block(c, 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule